// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus interface for a 16-bit processor-style master. It takes one request at a time and runs it as a bus cycle on a shared address/data bus. A request holds a segment, an offset, a direction, a space (memory or I/O), a transfer size and write data. The block builds a 20-bit physical address from the segment and offset. It then steps through the T-states T1, T2, T3, any number of wait states Tw, and T4.

In T1 the block drives the address and raises a latch enable, so an external transparent latch can capture the address. From T2 onward the low 16 bits of the bus carry data. A write keeps its data on the bus through T4. A read releases the bus so the device can drive it. The read or write strobe is low in T2, T3 and every Tw, and returns high in T4. A ready input, sampled on each rising edge, stretches the cycle while it is low.

The requester sees `req_ready` in idle and in T4, which lets it issue cycles back to back. It sees `rsp_done` in T4 together with the read result. A word request at an odd address is refused and reported with an error pulse.

Top module: `mbus_seq`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. In the first cycle after an accepted request (T1), it appears on `{bus_a_hi, bus_ad_out}`, with `bus_ad_oe` high.
- R2: With ready high when first sampled in T3, a cycle lasts exactly four clocks (T1 to T4), and `rsp_done` is high only in the fourth.
- R3: `bus_ale` is high for exactly one clock per cycle, in T1, and low at all other times.
- R4: Each rising edge in T3 or Tw at which `bus_rdy` is sampled low adds one Tw clock. T4 follows the first edge at which it is sampled high.
- R5: `bus_rd_n` is low in T2, T3 and Tw of a read, and `bus_wr_n` is low in the same states of a write. Both are high in T1, in T4, in idle and in reset, and they are never low together.
- R6: Lane encoding on (`bus_bhe_n`, address bit 0): a word transfer gives (0,0), a byte at an odd address gives (0,1), and a byte at an even address gives (1,0). The encoding is held from T1 through T4, and `bus_bhe_n` is 1 in idle.
- R7: A write drives data with `bus_ad_oe` high from T2 through T4, stable across the rising edge of `bus_wr_n`. A word write puts `req_wdata` on the bus. A byte write puts `req_wdata[7:0]` on both byte lanes.
- R8: A read keeps `bus_ad_oe` low from T2 through T4. The bus is captured on the edge at which ready is sampled high. A word read returns all 16 bits; a byte read returns the addressed lane (bits 15:8 for an odd address, 7:0 for an even one), zero-extended. The result is on `rsp_rdata` while `rsp_done` is high.
- R9: `req_ready` is high only in idle and T4. A request accepted in T4 starts T1 in the very next clock.
- R10: A word request at an odd address is refused. `rsp_err` is high for one clock, in the cycle after acceptance, and no bus cycle starts (`bus_ale` stays low).
- R11: `bus_mio` is 1 for a memory cycle and 0 for an I/O cycle, held from T1 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within segment |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_done | output | 1 | Cycle in T4 |
| rsp_err | output | 1 | Misaligned word refused |
| rsp_rdata | output | 16 | Read result |
| bus_ad_out | output | 16 | Shared bus, outgoing address/data |
| bus_ad_oe | output | 1 | Shared bus driver enable |
| bus_ad_in | input | 16 | Shared bus, incoming data |
| bus_a_hi | output | 4 | Address bits 19:16 |
| bus_ale | output | 1 | Address latch enable |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_mio | output | 1 | 1 = memory, 0 = I/O |
| bus_rdy | input | 1 | Device ready |

## Verification
A wrong T-state shows up within one clock at the pins. An extra or missing state changes the clock count from the latch-enable pulse to `rsp_done`, and a state entered out of order moves a strobe edge or the latch pulse. A mistimed capture returns the filler value the device model drives while ready is low, so `rsp_rdata` is wrong in that T4. A corrupted request register shows up at the next latch pulse as a wrong address, lane code or space bit, or as changing write data while the write strobe is low.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // Bus cycle states; TS_TW repeats while the device holds ready low.
    typedef enum logic [2:0] {
        TS_IDLE,
        TS_T1,
        TS_T2,
        TS_T3,
        TS_TW,
        TS_T4
    } tstate_e;

endpackage

// File: rtl/mbus_agen.sv
// Physical address formation and byte-lane decode for one request.
module mbus_agen #(
    parameter int SEGW  = 16,
    parameter int OFFW  = 16,
    parameter int SHIFT = 4,
    parameter int AW    = SEGW + SHIFT
) (
    input  logic [SEGW-1:0] seg,
    input  logic [OFFW-1:0] off,
    input  logic            word,
    output logic [AW-1:0]   phys,
    output logic            bhe_n,
    output logic            misalign
);

    logic [AW-1:0] seg_base;
    logic [AW-1:0] off_ext;

    always_comb begin
        seg_base = AW'({seg, {SHIFT{1'b0}}});
        off_ext  = AW'(off);
        phys     = seg_base + off_ext;
        // Upper lane is used by words and by odd-address bytes.
        bhe_n    = ~(word | phys[0]);
        misalign = word & phys[0];
    end

endmodule

// File: rtl/mbus_lanes.sv
// Byte-lane steering: write data toward the bus, read data from the bus.
module mbus_lanes #(
    parameter int DW = 16
) (
    input  logic          word,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_wr,
    output logic [DW-1:0] rd_val
);

    localparam int BW = DW / 2;

    always_comb begin
        if (word) begin
            bus_wr = wdata;
            rd_val = bus_in;
        end else begin
            // A byte write shows on both lanes; the enables pick one.
            bus_wr = {wdata[BW-1:0], wdata[BW-1:0]};
            if (a0) begin
                rd_val = {{BW{1'b0}}, bus_in[DW-1:BW]};
            end else begin
                rd_val = {{BW{1'b0}}, bus_in[BW-1:0]};
            end
        end
    end

endmodule

// File: rtl/mbus_fsm.sv
// T-state sequencer.
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    rdy,
    output tstate_e st,
    output logic    capture
);

    typedef struct packed {
        tstate_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            TS_IDLE: if (start) fsm_d.st = TS_T1;
            TS_T1:   fsm_d.st = TS_T2;
            TS_T2:   fsm_d.st = TS_T3;
            TS_T3:   fsm_d.st = rdy ? TS_T4 : TS_TW;
            TS_TW:   if (rdy) fsm_d.st = TS_T4;
            TS_T4:   fsm_d.st = start ? TS_T1 : TS_IDLE;
            default: fsm_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st <= TS_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign st      = fsm_q.st;
    assign capture = ((fsm_q.st == TS_T3) || (fsm_q.st == TS_TW)) && rdy;

endmodule

// File: rtl/mbus_seq.sv
// Multiplexed address/data bus cycle sequencer (top).
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEGW  = 16,
    parameter int OFFW  = 16,
    parameter int SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [SEGW-1:0]           req_seg,
    input  logic [OFFW-1:0]           req_off,
    input  logic                      req_write,
    input  logic                      req_io,
    input  logic                      req_word,
    input  logic [DW-1:0]             req_wdata,
    output logic                      req_ready,
    output logic                      rsp_done,
    output logic                      rsp_err,
    output logic [DW-1:0]             rsp_rdata,
    output logic [DW-1:0]             bus_ad_out,
    output logic                      bus_ad_oe,
    input  logic [DW-1:0]             bus_ad_in,
    output logic [SEGW+SHIFT-DW-1:0]  bus_a_hi,
    output logic                      bus_ale,
    output logic                      bus_bhe_n,
    output logic                      bus_rd_n,
    output logic                      bus_wr_n,
    output logic                      bus_mio,
    input  logic                      bus_rdy
);

    localparam int AW  = SEGW + SHIFT;
    localparam int HIW = AW - DW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          bhe_n;
        logic          write;
        logic          io;
        logic          word;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          err;
    } regs_t;

    regs_t   r_d, r_q;
    tstate_e st;
    logic    capture;
    logic    accept;
    logic    start;
    logic    busy;
    logic    strobe;
    logic    data_phase;
    logic [AW-1:0] a_phys;
    logic          a_bhe_n;
    logic          a_mis;
    logic [DW-1:0] lane_wbus;
    logic [DW-1:0] lane_rval;

    mbus_agen #(
        .SEGW (SEGW),
        .OFFW (OFFW),
        .SHIFT(SHIFT),
        .AW   (AW)
    ) u_agen (
        .seg     (req_seg),
        .off     (req_off),
        .word    (req_word),
        .phys    (a_phys),
        .bhe_n   (a_bhe_n),
        .misalign(a_mis)
    );

    mbus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rdy    (bus_rdy),
        .st     (st),
        .capture(capture)
    );

    mbus_lanes #(
        .DW(DW)
    ) u_lanes (
        .word  (r_q.word),
        .a0    (r_q.addr[0]),
        .wdata (r_q.wdata),
        .bus_in(bus_ad_in),
        .bus_wr(lane_wbus),
        .rd_val(lane_rval)
    );

    assign req_ready = (st == TS_IDLE) || (st == TS_T4);
    assign accept    = req_valid && req_ready;
    assign start     = accept && !a_mis;

    always_comb begin
        r_d     = r_q;
        r_d.err = accept && a_mis;
        if (start) begin
            r_d.addr  = a_phys;
            r_d.bhe_n = a_bhe_n;
            r_d.write = req_write;
            r_d.io    = req_io;
            r_d.word  = req_word;
            r_d.wdata = req_wdata;
        end
        if (capture && !r_q.write) begin
            r_d.rdata = lane_rval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (st != TS_IDLE);
    assign strobe     = st inside {TS_T2, TS_T3, TS_TW};
    assign data_phase = st inside {TS_T2, TS_T3, TS_TW, TS_T4};

    assign bus_ale    = (st == TS_T1);
    assign bus_ad_oe  = (st == TS_T1) || (data_phase && r_q.write);
    assign bus_ad_out = (st == TS_T1) ? r_q.addr[DW-1:0]
                      : ((data_phase && r_q.write) ? lane_wbus : '0);
    assign bus_a_hi   = busy ? r_q.addr[AW-1:AW-HIW] : '0;
    assign bus_bhe_n  = busy ? r_q.bhe_n : 1'b1;
    assign bus_mio    = busy ? ~r_q.io : 1'b1;
    assign bus_rd_n   = ~(strobe && !r_q.write);
    assign bus_wr_n   = ~(strobe && r_q.write);

    assign rsp_done  = (st == TS_T4);
    assign rsp_err   = r_q.err;
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/mbus_seq_chk.sv
// Protocol checker bound to the sequencer.
module mbus_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale,
    input logic          ad_oe,
    input logic [DW-1:0] ad_out,
    input logic          rd_n,
    input logic          wr_n,
    input logic          rdy,
    input logic          done,
    input logic          err,
    input logic          req_ready
);

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R1
    ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    // R2
    t2_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && !rdy) |=> (!rd_n || !wr_n));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R7
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (ad_oe && $stable(ad_out)));

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R10
    err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !ale);

endmodule

bind mbus_seq mbus_seq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (bus_ale),
    .ad_oe    (bus_ad_oe),
    .ad_out   (bus_ad_out),
    .rd_n     (bus_rd_n),
    .wr_n     (bus_wr_n),
    .rdy      (bus_rdy),
    .done     (rsp_done),
    .err      (rsp_err),
    .req_ready(req_ready)
);

// File: tb/tb_mbus_seq.sv
`timescale 1ns/1ps
module tb_mbus_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_seg;
    logic [15:0] req_off;
    logic        req_write;
    logic        req_io;
    logic        req_word;
    logic [15:0] req_wdata;
    logic        req_ready;
    logic        rsp_done;
    logic        rsp_err;
    logic [15:0] rsp_rdata;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in = 16'h0BAD;
    logic [3:0]  bus_a_hi;
    logic        bus_ale;
    logic        bus_bhe_n;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_mio;
    logic        bus_rdy = 1'b0;

    always #5 clk = ~clk;

    mbus_seq dut (.*);

    typedef struct {
        logic [19:0] addr;
        logic        bhe_n;
        logic        mio;
        logic        write;
        logic [15:0] bus;
        logic [15:0] rdata;
        int          waits;
    } exp_t;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Device model: ready after (waits) extra clocks, data valid with ready.
    int          wait_n   = 0;
    int          scnt     = 0;
    logic [19:0] dev_addr = '0;
    always @(negedge clk) begin
        if (bus_ale) dev_addr = {bus_a_hi, bus_ad_out};
        if (!bus_rd_n || !bus_wr_n) scnt++;
        else scnt = 0;
        bus_rdy   = (scnt >= 2 + wait_n);
        bus_ad_in = (bus_rdy && !bus_rd_n) ? (dev_addr[15:0] ^ 16'hA5C3) : 16'h0BAD;
    end

    // Monitor: observes each bus cycle and compares against the scoreboard.
    bit          in_cyc   = 0;
    bit          acc_prev = 0;
    int          ncyc     = 0;
    logic [19:0] m_addr;
    logic        m_bhe;
    logic        m_mio;
    logic [15:0] m_wd;
    bit          wd_seen, wr_bad, rd_bad;
    exp_t        e_cur;

    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (acc_prev) chk(bus_ale, "R9 T1 right after T4 accept", bus_ale, 1);
            acc_prev = rsp_done && req_valid;
            if (!bus_rd_n || !bus_wr_n) chk(!req_ready, "R9 ready low while busy", req_ready, 0);
            if (bus_ale) begin
                in_cyc  = 1;
                ncyc    = 1;
                m_addr  = {bus_a_hi, bus_ad_out};
                m_bhe   = bus_bhe_n;
                m_mio   = bus_mio;
                wd_seen = 0;
                wr_bad  = 0;
                rd_bad  = 0;
                chk(bus_ad_oe && bus_rd_n && bus_wr_n, "R1 address driven in T1", bus_ad_oe, 1);
            end else if (in_cyc) begin
                ncyc++;
                if (bus_bhe_n != m_bhe || bus_mio != m_mio) wr_bad = 1;
            end
            if (in_cyc && !bus_rd_n && bus_ad_oe) rd_bad = 1;
            if (in_cyc && !bus_wr_n) begin
                if (!bus_ad_oe || (wd_seen && bus_ad_out != m_wd)) wr_bad = 1;
                m_wd    = bus_ad_out;
                wd_seen = 1;
            end
            if (rsp_done && in_cyc) begin
                if (sb.size() == 0) begin
                    chk(0, "R2 unexpected done", 1, 0);
                end else begin
                    e_cur = sb.pop_front();
                    chk(m_addr == e_cur.addr, "R1 physical address", m_addr, e_cur.addr);
                    chk(m_bhe == e_cur.bhe_n, "R6 high-byte enable", m_bhe, e_cur.bhe_n);
                    chk(m_mio == e_cur.mio, "R11 space select", m_mio, e_cur.mio);
                    if (e_cur.waits == 0)
                        chk(ncyc == 4, "R2 zero-wait length", ncyc, 4);
                    else
                        chk(ncyc == 4 + e_cur.waits, "R4 stretched length", ncyc, 4 + e_cur.waits);
                    chk(bus_rd_n && bus_wr_n, "R5 strobes high in T4", {bus_rd_n, bus_wr_n}, 2'b11);
                    if (e_cur.write) begin
                        chk(wd_seen && !wr_bad && bus_ad_oe && bus_ad_out == e_cur.bus
                            && m_wd == e_cur.bus, "R7 write data", bus_ad_out, e_cur.bus);
                    end else begin
                        chk(!rd_bad && !bus_ad_oe, "R8 bus released on read", bus_ad_oe, 0);
                        chk(rsp_rdata == e_cur.rdata, "R8 read data", rsp_rdata, e_cur.rdata);
                    end
                end
                in_cyc = 0;
            end
        end
    end

    task automatic issue(input logic [15:0] seg, input logic [15:0] off,
                         input bit wr, input bit io, input bit word,
                         input logic [15:0] wd, input int waits);
        exp_t        e;
        logic [19:0] a;
        logic [15:0] f;
        a       = {seg, 4'h0} + {4'h0, off};
        f       = a[15:0] ^ 16'hA5C3;
        e.addr  = a;
        e.bhe_n = !(word || a[0]);
        e.mio   = !io;
        e.write = wr;
        e.bus   = word ? wd : {wd[7:0], wd[7:0]};
        e.rdata = word ? f : (a[0] ? {8'h00, f[15:8]} : {8'h00, f[7:0]});
        e.waits = waits;
        @(negedge clk);
        req_seg   = seg;
        req_off   = off;
        req_write = wr;
        req_io    = io;
        req_word  = word;
        req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        wait_n = waits;
        sb.push_back(e);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_seg   = '0;
        req_off   = '0;
        req_write = 1'b0;
        req_io    = 1'b0;
        req_word  = 1'b0;
        req_wdata = '0;
        repeat (4) @(negedge clk);
        chk(!bus_ale && !bus_ad_oe, "R3 reset: no latch pulse, bus idle", {bus_ale, bus_ad_oe}, 0);
        chk(bus_rd_n && bus_wr_n, "R5 reset: strobes high", {bus_rd_n, bus_wr_n}, 2'b11);
        chk(!rsp_done && !rsp_err && bus_bhe_n, "R6 reset: bhe high, no done", {rsp_done, rsp_err, bus_bhe_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R9 idle ready", req_ready, 1);

        // Word read, memory, no waits
        issue(16'h1234, 16'h0010, 0, 0, 1, 16'h0000, 0);
        drain();
        // Word write with waits, address wraps past 2^20
        issue(16'hFFFF, 16'h0020, 1, 0, 1, 16'hBEEF, 2);
        drain();
        // Byte read at odd address, I/O, one wait
        issue(16'h0040, 16'h0123, 0, 1, 0, 16'h0000, 1);
        drain();
        // Byte write at even address, I/O
        issue(16'h0000, 16'h03F8, 1, 1, 0, 16'h005A, 0);
        drain();
        // Byte read at even address, memory, three waits
        issue(16'hA000, 16'h7FFE, 0, 0, 0, 16'h0000, 3);
        drain();
        // Byte write at odd address, memory
        issue(16'h2000, 16'h0001, 1, 0, 0, 16'h1C3D, 1);
        drain();
        // Back-to-back: write then read then write
        issue(16'h0100, 16'h0002, 1, 0, 1, 16'h1357, 0);
        issue(16'h0100, 16'h0004, 0, 0, 1, 16'h0000, 1);
        issue(16'h0200, 16'h0006, 1, 1, 1, 16'h2468, 0);
        drain();

        // Misaligned word: refused with error, no cycle
        @(negedge clk);
        req_seg   = 16'h0300;
        req_off   = 16'h0005;
        req_write = 1'b0;
        req_io    = 1'b0;
        req_word  = 1'b1;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        #2;
        chk(rsp_err, "R10 error flag", rsp_err, 1);
        chk(!bus_ale && bus_rd_n, "R10 no cycle started", {bus_ale, bus_rd_n}, 2'b01);
        @(negedge clk);
        #2;
        chk(!rsp_err, "R10 error lasts one clock", rsp_err, 0);
        chk(req_ready && !bus_ale, "R10 back in idle", {req_ready, bus_ale}, 2'b10);

        // Long stretch
        issue(16'h0F00, 16'h00A0, 0, 0, 1, 16'h0000, 10);
        drain();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule